// File: doc/BRIEF.md
# Four-Port Phase-Staggered PWM LED Dimmer

This block produces the current-sink enable lines for a group of LED driver ports. One free-running step counter defines a 256-step dimming cycle. Every port reads that counter at its own phase offset, so the cycles of the ports start one eighth of a cycle apart. This spreads the turn-on edges and limits supply current spikes when several LEDs are lit at once. Each port takes its brightness code either from its own duty register or from one shared duty register, as its select bit chooses.

A brightness code in 0..254 lights the port for that number of steps at the start of its own cycle. Code 255 lights the port for the whole cycle. The code and the source selection go into a per-port shadow register, and that register loads only when the port's cycle restarts. A host can therefore rewrite the live registers at any time without producing a shortened or stretched pulse. The counter moves only on a clock-enable tick from an upstream prescaler. A global enable stops the whole group, and per-port enables take single ports out of PWM use.

Top module: `led_pwm_dimmer`

## Requirements
- R1: While `rst` is high (synchronous, active high), the step counter clears to 0 and every shadow code clears to 0, so all `sink_on` bits read 0 after the reset edge.
- R2: While `glb_en` is high, the step counter advances by one only on a clock edge with `tick` high and wraps from 255 to 0; with `tick` low the counter and all outputs hold.
- R3: For a shadow code d in 0..254, port i is on exactly for its local steps 0..d-1, where local step = (counter − offset_i) mod 256; this gives d on-steps per 256-step cycle, and code 0 is never on.
- R4: A shadow code of 255 (all ones) keeps the port on for all 256 steps of its cycle.
- R5: Bit i of `use_common` selects the source for port i: 1 takes `duty_common`, 0 takes bits [8i+7:8i] of `duty_own`.
- R6: The offset of port i is 32·i steps (0, 32, 64, 96), so from a cycle start at counter 0 each port's first on-step comes 32 steps after the previous port's.
- R7: A port's shadow code loads from its selected live source only on the tick that moves the counter onto that port's offset; a change to the live code or to the select bit in the middle of a cycle has no effect until that port's next cycle begins.
- R8: With `port_en[i]` low, `sink_on[i]` is 0, and the other ports are not affected.
- R9: With `glb_en` low, all `sink_on` bits are 0, the counter is held at 0, and every shadow code follows its selected live source on each clock, so a newly enabled group starts a fresh cycle at counter 0 with the current codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Step clock-enable from the PWM prescaler |
| glb_en | input | 1 | Global enable for the whole dimmer group |
| port_en | input | NUM_PORTS | Per-port LED driver enable |
| use_common | input | NUM_PORTS | Per-port source select: 1 = common code, 0 = own code |
| duty_own | input | NUM_PORTS*CODE_W | Packed individual duty codes, port i in bits [CODE_W*i+CODE_W-1 : CODE_W*i] |
| duty_common | input | CODE_W | Shared duty code |
| sink_on | output | NUM_PORTS | Active-high current-sink enable per port |

## Verification
The bench builds the block with its default values: four ports and an 8-bit code, which gives a 256-step cycle and a 32-step stagger. With these values a full cycle of every port fits in a few hundred clocks, so the bench can count on-steps over whole cycles for codes 0, 1, 128, 254 and 255. It can also measure each port's first on-step against the 32-step spacing. A behavioural model of counter, shadows and compare runs beside the design and is checked against it on every clock. The test phases include sparse ticks, a code change injected in the middle of a cycle, and switching the global enable off and on again.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

    // Where a port takes its brightness code from.
    typedef enum logic {
        SRC_OWN    = 1'b0,
        SRC_COMMON = 1'b1
    } duty_src_e;

    // Number of phase slots in one cycle (45-degree spacing).
    localparam int unsigned PHASE_SLOTS = 8;

    // Phase offset of a port in steps, for a cycle of 2**code_w steps.
    function automatic int unsigned port_offset(int unsigned port, int unsigned code_w);
        int unsigned cycle_len;
        cycle_len = 1 << code_w;
        return (port * (cycle_len / PHASE_SLOTS)) % cycle_len;
    endfunction

endpackage

// File: rtl/led_pwm_step_ctr.sv
module led_pwm_step_ctr #(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    output logic [CODE_W-1:0] step,
    output logic [CODE_W-1:0] step_next
);

    logic [CODE_W-1:0] step_q;

    // Value the counter takes on the next advancing tick (wraps naturally).
    assign step_next = step_q + CODE_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            step_q <= '0;
        end else if (tick) begin
            step_q <= step_next;
        end
    end

    assign step = step_q;

endmodule

// File: rtl/led_pwm_port.sv
module led_pwm_port
    import led_pwm_pkg::*;
#(
    parameter int unsigned      CODE_W = 8,
    parameter logic [CODE_W-1:0] OFFSET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic [CODE_W-1:0] step,
    input  logic [CODE_W-1:0] step_next,
    input  logic              port_en,
    input  duty_src_e         src_sel,
    input  logic [CODE_W-1:0] own_code,
    input  logic [CODE_W-1:0] common_code,
    output logic              sink
);

    logic [CODE_W-1:0] live_code;
    logic [CODE_W-1:0] shadow_q;
    logic [CODE_W-1:0] local_step;
    logic              cycle_restart;
    logic              lit;

    always_comb begin
        unique case (src_sel)
            SRC_COMMON: live_code = common_code;
            default:    live_code = own_code;
        endcase
    end

    // The next tick puts the counter onto this port's offset.
    assign cycle_restart = tick && (step_next == OFFSET);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (!run || cycle_restart) begin
            shadow_q <= live_code;
        end
    end

    assign local_step = step - OFFSET;

    // All-ones code means on for the whole cycle.
    assign lit  = (&shadow_q) || (local_step < shadow_q);
    assign sink = run && port_en && lit;

endmodule

// File: rtl/led_pwm_dimmer.sv
module led_pwm_dimmer
    import led_pwm_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned CODE_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    input  logic                          glb_en,
    input  logic [NUM_PORTS-1:0]          port_en,
    input  logic [NUM_PORTS-1:0]          use_common,
    input  logic [NUM_PORTS*CODE_W-1:0]   duty_own,
    input  logic [CODE_W-1:0]             duty_common,
    output logic [NUM_PORTS-1:0]          sink_on
);

    logic [CODE_W-1:0] step_q;
    logic [CODE_W-1:0] step_nx;

    led_pwm_step_ctr #(
        .CODE_W (CODE_W)
    ) i_step (
        .clk       (clk),
        .rst       (rst),
        .run       (glb_en),
        .tick      (tick),
        .step      (step_q),
        .step_next (step_nx)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        localparam logic [CODE_W-1:0] OFS = CODE_W'(port_offset(g, CODE_W));

        duty_src_e sel;
        assign sel = use_common[g] ? SRC_COMMON : SRC_OWN;

        led_pwm_port #(
            .CODE_W (CODE_W),
            .OFFSET (OFS)
        ) i_port (
            .clk         (clk),
            .rst         (rst),
            .run         (glb_en),
            .tick        (tick),
            .step        (step_q),
            .step_next   (step_nx),
            .port_en     (port_en[g]),
            .src_sel     (sel),
            .own_code    (duty_own[g*CODE_W +: CODE_W]),
            .common_code (duty_common),
            .sink        (sink_on[g])
        );
    end

endmodule

// File: rtl/led_pwm_dimmer_chk.sv
module led_pwm_dimmer_chk #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned CODE_W    = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick,
    input logic                 glb_en,
    input logic [NUM_PORTS-1:0] port_en,
    input logic [CODE_W-1:0]    step,
    input logic [NUM_PORTS-1:0] sink_on
);

    // R1: reset leaves outputs dark and the counter at zero
    assert_reset_dark_R1: assert property (@(posedge clk)
        rst |=> (sink_on == '0) && (step == '0));

    // R2: counter holds without a tick
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (glb_en && !tick) |=> ($stable(step) || !glb_en));

    // R2: counter wraps from the top value to zero
    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (glb_en && tick && (step == '1)) |=> ((step == '0) || !glb_en));

    // R2: outputs stay put when nothing advances
    assert_quiet_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (glb_en && !tick) |=> ($stable(sink_on) || !glb_en || !$stable(port_en)));

    // R8: a disabled port never sinks
    assert_port_off_R8: assert property (@(posedge clk) disable iff (rst)
        (sink_on & ~port_en) == '0);

    // R9: global disable darkens all ports and parks the counter
    assert_global_off_R9: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> (sink_on == '0));

    assert_park_R9: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> (step == '0));

endmodule

bind led_pwm_dimmer led_pwm_dimmer_chk #(
    .NUM_PORTS (NUM_PORTS),
    .CODE_W    (CODE_W)
) i_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .glb_en  (glb_en),
    .port_en (port_en),
    .step    (step_q),
    .sink_on (sink_on)
);

// File: tb/test_led_pwm_dimmer.sv
`timescale 1ns/1ps
module test_led_pwm_dimmer;

    localparam int NP  = 4;
    localparam int CW  = 8;
    localparam int LEN = 256;
    localparam int SEP = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            tick;
    logic            glb_en;
    logic [NP-1:0]   port_en;
    logic [NP-1:0]   use_common;
    logic [CW-1:0]   own_b [NP];
    logic [NP*CW-1:0] duty_own;
    logic [CW-1:0]   duty_common;
    logic [NP-1:0]   sink_on;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) duty_own[i*CW +: CW] = own_b[i];
    end

    led_pwm_dimmer #(.NUM_PORTS(NP), .CODE_W(CW)) i_led_pwm_dimmer (
        .clk(clk), .rst(rst), .tick(tick), .glb_en(glb_en),
        .port_en(port_en), .use_common(use_common), .duty_own(duty_own),
        .duty_common(duty_common), .sink_on(sink_on)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 0;

    // Behavioural reference
    int m_cnt;
    int m_sh [NP];

    function automatic int live_of(int i);
        return use_common[i] ? int'(duty_common) : int'(own_b[i]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            for (int i = 0; i < NP; i++) m_sh[i] = 0;
        end else if (!glb_en) begin
            m_cnt = 0;
            for (int i = 0; i < NP; i++) m_sh[i] = live_of(i);
        end else if (tick) begin
            m_cnt = (m_cnt + 1) % LEN;
            for (int i = 0; i < NP; i++)
                if (m_cnt == i*SEP) m_sh[i] = live_of(i);
        end
    end

    function automatic logic [NP-1:0] model_out();
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) begin
            int loc;
            loc = (m_cnt - i*SEP + LEN) % LEN;
            r[i] = !rst && glb_en && port_en[i] && (m_sh[i] == LEN-1 || loc < m_sh[i]);
        end
        return r;
    endfunction

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            logic [NP-1:0] e;
            e = model_out();
            n_checks++;
            if (sink_on !== e) begin
                n_fail++;
                $display("FAIL %s sink_on got %b exp %b at t=%0t", cur_req, sink_on, e, $time);
            end
        end
    end

    task automatic check(string req, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
        end
    endtask

    task automatic step_in();
        @(posedge clk); #1;
    endtask

    // Restart from counter 0 with the given codes, then count on-steps over
    // one 256-step window and note each port's first on-step.
    int on_cnt [NP];
    int first  [NP];

    task automatic window(int chg_at, int chg_port, int chg_code);
        glb_en = 1'b0;
        step_in(); step_in();
        glb_en = 1'b1;
        tick   = 1'b1;
        for (int i = 0; i < NP; i++) begin on_cnt[i] = 0; first[i] = -1; end
        for (int k = 0; k < LEN; k++) begin
            #2;
            for (int i = 0; i < NP; i++) if (sink_on[i]) begin
                on_cnt[i]++;
                if (first[i] < 0) first[i] = k;
            end
            if (k == chg_at) own_b[chg_port] = CW'(chg_code);
            @(posedge clk); #1;
        end
    endtask

    initial begin
        rst = 1'b1; tick = 1'b0; glb_en = 1'b0; port_en = '1; use_common = '0;
        duty_common = '0;
        for (int i = 0; i < NP; i++) own_b[i] = 8'd0;
        repeat (3) step_in();
        #2; check("R1", "sink_on in reset", int'(sink_on), 0);
        rst = 1'b0;
        step_in();
        #2; check("R1", "sink_on after reset", int'(sink_on), 0);

        // R3: several own codes
        cur_req = "R3";
        own_b[0] = 8'd0; own_b[1] = 8'd1; own_b[2] = 8'd128; own_b[3] = 8'd254;
        window(-1, 0, 0);
        check("R3", "port0 on-steps code 0",   on_cnt[0], 0);
        check("R3", "port1 on-steps code 1",   on_cnt[1], 1);
        check("R3", "port2 on-steps code 128", on_cnt[2], 128);
        check("R3", "port3 on-steps code 254", on_cnt[3], 254);

        // R6: stagger of the first on-step
        cur_req = "R6";
        for (int i = 0; i < NP; i++) own_b[i] = 8'd10;
        window(-1, 0, 0);
        for (int i = 0; i < NP; i++) check("R6", $sformatf("port%0d first on-step", i), first[i], i*SEP);

        // R4, R5: common vs own sources, full-on code
        cur_req = "R5";
        duty_common = 8'hFF; use_common = 4'b0101;
        own_b[0] = 8'd5; own_b[1] = 8'd3; own_b[2] = 8'd7; own_b[3] = 8'd200;
        window(-1, 0, 0);
        check("R4", "port0 common 0xFF on-steps", on_cnt[0], 256);
        check("R4", "port2 common 0xFF on-steps", on_cnt[2], 256);
        check("R5", "port1 own on-steps", on_cnt[1], 3);
        check("R5", "port3 own on-steps", on_cnt[3], 200);
        duty_common = 8'd40; use_common = 4'b1010;
        window(-1, 0, 0);
        check("R5", "port1 common 40", on_cnt[1], 40);
        check("R5", "port0 own 5", on_cnt[0], 5);

        // R8: per-port enables
        cur_req = "R8";
        use_common = '0; port_en = 4'b1010;
        for (int i = 0; i < NP; i++) own_b[i] = 8'd100;
        window(-1, 0, 0);
        check("R8", "port0 disabled", on_cnt[0], 0);
        check("R8", "port2 disabled", on_cnt[2], 0);
        check("R8", "port1 enabled", on_cnt[1], 100);
        check("R8", "port3 enabled", on_cnt[3], 100);
        port_en = '1;

        // R7: mid-cycle change is deferred to the next cycle
        cur_req = "R7";
        own_b[0] = 8'd50;
        window(20, 0, 200);
        check("R7", "port0 keeps old code in running cycle", on_cnt[0], 50);
        for (int i = 0; i < NP; i++) begin on_cnt[i] = 0; end
        for (int k = 0; k < LEN; k++) begin
            #2; if (sink_on[0]) on_cnt[0]++;
            @(posedge clk); #1;
        end
        check("R7", "port0 takes new code next cycle", on_cnt[0], 200);

        // R2: sparse ticks and hold
        cur_req = "R2";
        for (int k = 0; k < 900; k++) begin
            tick = (k % 3 == 0);
            step_in();
        end
        tick = 1'b0;
        begin
            logic [NP-1:0] held;
            #2; held = sink_on;
            repeat (20) step_in();
            #2; check("R2", "outputs held without tick", int'(sink_on), int'(held));
        end
        tick = 1'b1;
        repeat (300) step_in();

        // R9: global disable
        cur_req = "R9";
        glb_en = 1'b0; own_b[0] = 8'd255;
        step_in();
        #2; check("R9", "all dark while disabled", int'(sink_on), 0);
        own_b[0] = 8'd77;
        step_in();
        glb_en = 1'b1;
        for (int i = 0; i < NP; i++) on_cnt[i] = 0;
        for (int k = 0; k < LEN; k++) begin
            #2; if (sink_on[0]) on_cnt[0]++;
            if (k == 0) check("R9", "port0 on at restart step 0", int'(sink_on[0]), 1);
            @(posedge clk); #1;
        end
        check("R9", "shadow reloaded while disabled", on_cnt[0], 77);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule